// File: doc/BRIEF.md
# Layered Recovery Ladder Controller

This block decides how hard to hit a misbehaving bus controller after a fault. It takes a classified fault event and picks the mildest recovery step that the evidence supports. The steps, from mild to severe, are a bounded retry, an endpoint reset, a port reset, a controller-domain reset and a full re-enumeration. Every step is preceded by a quiesce phase: new submissions are frozen and in-flight work is drained before the step's strobe is issued. After the strobe the block requests a health probe. A passing probe ends the episode. A failing probe moves one rung up the ladder and quiesces again.

Three guards stop retry storms. Repeated retries back off exponentially, and after a fixed number of retries the block goes straight to an endpoint reset. A storm detector watches the retry rate, the p95 completion latency and the backlog trend. While a storm is present it keeps submissions frozen and pushes each new fault one rung higher. Re-enumerations are counted, and once the cap is reached a cooldown timer holds any further re-enumeration until it expires. A held request is delayed, never discarded. The reset datapaths and the collection of the health figures sit outside the block.

Top module: `recovery_ladder`

## Requirements
- R1: After reset the block is idle: `busy`, `freeze`, `drain_req`, `act_valid`, `probe_req`, `storm` and `enum_held` are 0, and `cur_level` is 0.
- R2: Levels are encoded as 1 retry, 2 endpoint reset, 3 port reset, 4 controller-domain reset and 5 re-enumeration. A fault with class 0 (transaction), 1 (endpoint stall), 2 (port-wide) or 3 (controller halt) selects level 1, 2, 3 or 4 respectively. The selected level appears on `act_level` together with the one-cycle `act_valid` strobe.
- R3: Every action is preceded by a quiesce phase with `freeze` and `drain_req` high. `act_valid` never rises before `drain_done` has been accepted, and `drain_req` falls in the cycle after `drain_done` is accepted.
- R4: Let k be the number of retries since the retry budget was last restored. The retry strobe comes BACKOFF_BASE·2^k + 1 cycles after the cycle in which `drain_done` is accepted. Levels 2 to 4 strobe 1 cycle after it.
- R5: After RETRY_MAX retries, a transaction fault selects an endpoint reset instead of a retry. A passing probe at level 2 or above restores the retry budget to zero.
- R6: In the cycle after `act_valid`, `probe_req` rises and stays high with `freeze` until `probe_done`.
- R7: A passing probe returns the block to idle with `cur_level` 0. `freeze` is released unless a storm is present.
- R8: A failing probe raises `cur_level` by one, up to a maximum of 5, and starts a new quiesce phase. A failure at level 5 repeats level 5.
- R9: A storm is present while `retry_rate` ≥ RATE_LIMIT or `lat_p95` ≥ LAT_LIMIT. During a storm `freeze` is high even when the block is idle, and a new fault selects one level above its class mapping, capped at 5.
- R10: STALL_WINDOWS consecutive `window_tick` pulses without `backlog_falling` also declare a storm. A tick with `backlog_falling` clears that condition.
- R11: Once ENUM_MAX re-enumerations have been issued, a cooldown of COOLDOWN cycles starts. A re-enumeration requested during the cooldown is held with `enum_held` high and is issued after the cooldown ends, at least COOLDOWN cycles after the previous one.
- R12: A fault that arrives while a recovery is in progress is ignored. It changes neither `cur_level` nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault event strobe |
| fault_class | input | 2 | Fault class: 0 transaction, 1 endpoint stall, 2 port-wide, 3 controller halt |
| retry_rate | input | RATE_W | Measured retries per second |
| lat_p95 | input | LAT_W | Measured p95 completion latency |
| window_tick | input | 1 | End of a measurement window |
| backlog_falling | input | 1 | Backlog decreased in the window that just ended |
| drain_done | input | 1 | In-flight work has drained |
| probe_done | input | 1 | Health probe finished |
| probe_ok | input | 1 | Health probe passed; valid with `probe_done` |
| freeze | output | 1 | Block new submissions |
| drain_req | output | 1 | Request drain of in-flight work |
| act_valid | output | 1 | One-cycle recovery action strobe |
| act_level | output | 3 | Level of the action (1..5) |
| probe_req | output | 1 | Request a health probe |
| cur_level | output | 3 | Current ladder level, 0 when idle |
| busy | output | 1 | A recovery episode is in progress |
| storm | output | 1 | Storm condition present |
| enum_held | output | 1 | A re-enumeration is waiting for the cooldown to end |

## Verification
The assertions take the handshake inputs as well-behaved. `drain_done` is assumed to pulse only while `drain_req` is high, and `probe_done` only while `probe_req` is high. `fault_class` is assumed to matter only in a cycle with `fault_valid`. The bench respects these assumptions by construction: it raises `drain_done` and `probe_done` for a single cycle, and only after it has seen the matching request at a falling edge. It raises faults, metric levels and window ticks only between episodes, except for the one deliberate fault injected mid-episode to check R12.

// File: rtl/rl_pkg.sv
package rl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_QUIESCE = 3'd1,
        ST_WAIT    = 3'd2,
        ST_ACT     = 3'd3,
        ST_PROBE   = 3'd4
    } rl_state_e;

    localparam logic [2:0] LVL_NONE  = 3'd0;
    localparam logic [2:0] LVL_RETRY = 3'd1;
    localparam logic [2:0] LVL_EP    = 3'd2;
    localparam logic [2:0] LVL_PORT  = 3'd3;
    localparam logic [2:0] LVL_CTRL  = 3'd4;
    localparam logic [2:0] LVL_ENUM  = 3'd5;

    // Class code c maps to ladder level c+1 (transaction..controller halt).
    function automatic logic [2:0] class_to_level(input logic [1:0] cls);
        return {1'b0, cls} + 3'd1;
    endfunction

endpackage

// File: rtl/rl_storm.sv
module rl_storm #(
    parameter int RATE_W        = 8,
    parameter int RATE_LIMIT    = 200,
    parameter int LAT_W         = 8,
    parameter int LAT_LIMIT     = 100,
    parameter int STALL_WINDOWS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] retry_rate,
    input  logic [LAT_W-1:0]  lat_p95,
    input  logic              window_tick,
    input  logic              backlog_falling,
    output logic              storm
);
    localparam int SW = $clog2(STALL_WINDOWS + 1);

    typedef struct packed {
        logic [SW-1:0] stale;
        logic          storm;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (window_tick) begin
            if (backlog_falling)
                s_d.stale = '0;
            else if (s_q.stale != SW'(STALL_WINDOWS))
                s_d.stale = s_q.stale + SW'(1);
        end
        s_d.storm = (retry_rate >= RATE_W'(RATE_LIMIT))
                 || (lat_p95 >= LAT_W'(LAT_LIMIT))
                 || (s_q.stale >= SW'(STALL_WINDOWS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign storm = s_q.storm;

endmodule

// File: rtl/rl_reenum_gate.sv
module rl_reenum_gate #(
    parameter int ENUM_MAX = 2,
    parameter int COOLDOWN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic cool_busy
);
    localparam int EW = $clog2(ENUM_MAX + 1);
    localparam int CW = $clog2(COOLDOWN + 1);

    typedef struct packed {
        logic [EW-1:0] count;
        logic [CW-1:0] cool;
    } gate_t;

    gate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cool != '0) begin
            s_d.cool = s_q.cool - CW'(1);
            if (s_q.cool == CW'(1))
                s_d.count = '0;
        end
        if (issue && (s_q.count != EW'(ENUM_MAX))) begin
            s_d.count = s_q.count + EW'(1);
            if (s_q.count + EW'(1) == EW'(ENUM_MAX))
                s_d.cool = CW'(COOLDOWN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cool_busy = (s_q.cool != '0);

endmodule

// File: rtl/recovery_ladder.sv
module recovery_ladder
    import rl_pkg::*;
#(
    parameter int RETRY_MAX     = 3,
    parameter int BACKOFF_BASE  = 2,
    parameter int RATE_W        = 8,
    parameter int RATE_LIMIT    = 200,
    parameter int LAT_W         = 8,
    parameter int LAT_LIMIT     = 100,
    parameter int STALL_WINDOWS = 4,
    parameter int ENUM_MAX      = 2,
    parameter int COOLDOWN      = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [1:0]        fault_class,
    input  logic [RATE_W-1:0] retry_rate,
    input  logic [LAT_W-1:0]  lat_p95,
    input  logic              window_tick,
    input  logic              backlog_falling,
    input  logic              drain_done,
    input  logic              probe_done,
    input  logic              probe_ok,
    output logic              freeze,
    output logic              drain_req,
    output logic              act_valid,
    output logic [2:0]        act_level,
    output logic              probe_req,
    output logic [2:0]        cur_level,
    output logic              busy,
    output logic              storm,
    output logic              enum_held
);
    localparam int RW     = $clog2(RETRY_MAX + 1);
    localparam int WAIT_W = $clog2((BACKOFF_BASE << RETRY_MAX) + 1);

    typedef struct packed {
        rl_state_e        state;
        logic [2:0]       level;
        logic [RW-1:0]    retries;
        logic [WAIT_W-1:0] wait_cnt;
    } ctl_t;

    ctl_t       s_d, s_q;
    logic       storm_w;
    logic       cool_busy;
    logic       enum_issue;
    logic [2:0] tgt;

    rl_storm #(
        .RATE_W(RATE_W), .RATE_LIMIT(RATE_LIMIT),
        .LAT_W(LAT_W), .LAT_LIMIT(LAT_LIMIT),
        .STALL_WINDOWS(STALL_WINDOWS)
    ) u_storm (
        .clk(clk), .rst_n(rst_n),
        .retry_rate(retry_rate), .lat_p95(lat_p95),
        .window_tick(window_tick), .backlog_falling(backlog_falling),
        .storm(storm_w)
    );

    assign enum_issue = (s_q.state == ST_ACT) && (s_q.level == LVL_ENUM);

    rl_reenum_gate #(.ENUM_MAX(ENUM_MAX), .COOLDOWN(COOLDOWN)) u_gate (
        .clk(clk), .rst_n(rst_n), .issue(enum_issue), .cool_busy(cool_busy)
    );

    always_comb begin
        s_d = s_q;
        tgt = class_to_level(fault_class);
        if (tgt == LVL_RETRY && s_q.retries == RW'(RETRY_MAX))
            tgt = LVL_EP;
        if (storm_w && tgt < LVL_ENUM)
            tgt = tgt + 3'd1;
        case (s_q.state)
            ST_IDLE: begin
                if (fault_valid) begin
                    s_d.level = tgt;
                    s_d.state = ST_QUIESCE;
                end
            end
            ST_QUIESCE: begin
                if (drain_done) begin
                    s_d.state    = ST_WAIT;
                    s_d.wait_cnt = (s_q.level == LVL_RETRY)
                                 ? (WAIT_W'(BACKOFF_BASE) << s_q.retries) : '0;
                end
            end
            ST_WAIT: begin
                if (s_q.level == LVL_ENUM) begin
                    if (!cool_busy) s_d.state = ST_ACT;
                end else if (s_q.wait_cnt == '0) begin
                    s_d.state = ST_ACT;
                end else begin
                    s_d.wait_cnt = s_q.wait_cnt - WAIT_W'(1);
                end
            end
            ST_ACT: begin
                s_d.state = ST_PROBE;
                if (s_q.level == LVL_RETRY)
                    s_d.retries = s_q.retries + RW'(1);
            end
            ST_PROBE: begin
                if (probe_done) begin
                    if (probe_ok) begin
                        s_d.state = ST_IDLE;
                        s_d.level = LVL_NONE;
                        if (s_q.level >= LVL_EP) s_d.retries = '0;
                    end else begin
                        s_d.state = ST_QUIESCE;
                        if (s_q.level < LVL_ENUM) s_d.level = s_q.level + 3'd1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.level    <= LVL_NONE;
            s_q.retries  <= '0;
            s_q.wait_cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign freeze    = storm_w || busy;
    assign drain_req = (s_q.state == ST_QUIESCE);
    assign act_valid = (s_q.state == ST_ACT);
    assign act_level = act_valid ? s_q.level : LVL_NONE;
    assign probe_req = (s_q.state == ST_PROBE);
    assign cur_level = s_q.level;
    assign storm     = storm_w;
    assign enum_held = (s_q.state == ST_WAIT) && (s_q.level == LVL_ENUM) && cool_busy;

endmodule

// File: rtl/rl_checker.sv
module rl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       drain_done,
    input logic       probe_done,
    input logic       probe_ok,
    input logic       freeze,
    input logic       drain_req,
    input logic       act_valid,
    input logic [2:0] act_level,
    input logic       probe_req,
    input logic [2:0] cur_level,
    input logic       busy,
    input logic       storm,
    input logic       enum_held
);
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cur_level == 3'd0));

    p_act_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_level >= 3'd1 && act_level <= 3'd5 && act_level == cur_level));

    p_quiesced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (freeze && !drain_req));

    p_probe_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> (probe_req && !act_valid));

    p_probe_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |-> freeze);

    p_pass_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && probe_done && probe_ok) |=> (!busy && cur_level == 3'd0));

    p_escalate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && probe_done && !probe_ok && cur_level < 3'd5)
        |=> (drain_req && cur_level == $past(cur_level) + 3'd1));

    p_storm_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        storm |-> freeze);

    p_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        enum_held |-> (!act_valid && cur_level == 3'd5));

endmodule

bind recovery_ladder rl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .drain_done(drain_done), .probe_done(probe_done),
    .probe_ok(probe_ok), .freeze(freeze), .drain_req(drain_req),
    .act_valid(act_valid), .act_level(act_level), .probe_req(probe_req),
    .cur_level(cur_level), .busy(busy), .storm(storm), .enum_held(enum_held)
);

// File: tb/sim_recovery_ladder.sv
module sim_recovery_ladder;
    localparam int BASE = 2;
    localparam int RMAX = 3;
    localparam int COOL = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_valid = 1'b0;
    logic [1:0] fault_class = 2'd0;
    logic [7:0] retry_rate = 8'd0;
    logic [7:0] lat_p95 = 8'd0;
    logic       window_tick = 1'b0;
    logic       backlog_falling = 1'b0;
    logic       drain_done = 1'b0;
    logic       probe_done = 1'b0;
    logic       probe_ok = 1'b0;
    logic       freeze, drain_req, act_valid, probe_req, busy, storm, enum_held;
    logic [2:0] act_level, cur_level;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    recovery_ladder u0 (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_class(fault_class),
        .retry_rate(retry_rate), .lat_p95(lat_p95), .window_tick(window_tick),
        .backlog_falling(backlog_falling), .drain_done(drain_done),
        .probe_done(probe_done), .probe_ok(probe_ok), .freeze(freeze),
        .drain_req(drain_req), .act_valid(act_valid), .act_level(act_level),
        .probe_req(probe_req), .cur_level(cur_level), .busy(busy),
        .storm(storm), .enum_held(enum_held)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic raise_fault(input logic [1:0] cls);
        @(negedge clk);
        fault_valid = 1'b1;
        fault_class = cls;
        @(negedge clk);
        fault_valid = 1'b0;
    endtask

    task automatic step(input int exp_lvl, input int exp_wait, input bit ok,
                        input string req, output int n, output bit held, output int t_act);
        int guard = 0;
        n = 0;
        held = 1'b0;
        while (!drain_req && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(drain_req && freeze && !act_valid, "R3 quiesce precedes action", drain_req, 1);
        drain_done = 1'b1;
        @(negedge clk);
        drain_done = 1'b0;
        check(!drain_req, "R3 drain released", drain_req, 0);
        while (!act_valid && n < 1000) begin
            if (enum_held) held = 1'b1;
            n++;
            @(negedge clk);
        end
        t_act = cyc;
        check(act_valid && act_level == 3'(exp_lvl), req, act_level, exp_lvl);
        if (exp_wait >= 0) check(n == exp_wait, "R4 cycles before strobe", n, exp_wait);
        @(negedge clk);
        check(probe_req && freeze && !act_valid, "R6 probe held under freeze", probe_req, 1);
        probe_done = 1'b1;
        probe_ok = ok;
        @(negedge clk);
        probe_done = 1'b0;
        probe_ok = 1'b0;
    endtask

    task automatic expect_idle(input bit frz, input string req);
        check(!busy && cur_level == 3'd0, req, cur_level, 0);
        check(freeze == frz, req, freeze, frz);
    endtask

    task automatic tick(input bit falling);
        @(negedge clk);
        window_tick = 1'b1;
        backlog_falling = falling;
        @(negedge clk);
        window_tick = 1'b0;
        backlog_falling = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n, t1, t2, t3;
        bit held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !freeze && !drain_req && !act_valid && !probe_req && !storm
              && !enum_held && cur_level == 3'd0, "R1 reset state", busy, 0);

        // R2 class sweep 1..3, R7 return to idle
        for (int c = 1; c < 4; c++) begin
            raise_fault(2'(c));
            step(c + 1, 1, 1'b1, "R2 class to level", n, held, t1);
            expect_idle(1'b0, "R7 idle after pass");
        end

        // R4 exponential backoff over retries
        for (int k = 0; k < RMAX; k++) begin
            raise_fault(2'd0);
            step(1, (BASE << k) + 1, 1'b1, "R2 transaction retry", n, held, t1);
            expect_idle(1'b0, "R7 idle after retry");
        end
        // R5 budget spent: endpoint reset, then budget restored
        raise_fault(2'd0);
        step(2, 1, 1'b1, "R5 retry cap selects endpoint reset", n, held, t1);
        raise_fault(2'd0);
        step(1, BASE + 1, 1'b1, "R5 budget restored", n, held, t1);

        // R8 escalation through every level, R11 cooldown
        raise_fault(2'd0);
        step(1, (BASE << 1) + 1, 1'b0, "R8 retry fails", n, held, t1);
        for (int l = 2; l < 5; l++) begin
            check(cur_level == 3'(l) && drain_req, "R8 escalated", cur_level, l);
            step(l, 1, 1'b0, "R8 ladder level", n, held, t1);
        end
        check(cur_level == 3'd5, "R8 reached re-enumeration", cur_level, 5);
        step(5, 1, 1'b0, "R8 first re-enumeration", n, held, t1);
        check(cur_level == 3'd5, "R8 stays at top", cur_level, 5);
        step(5, 1, 1'b0, "R11 second re-enumeration free", n, held, t2);
        step(5, -1, 1'b1, "R11 held re-enumeration issued", n, held, t3);
        check(held, "R11 enum_held seen", held, 1);
        check(t3 - t2 >= COOL, "R11 cooldown gap", t3 - t2, COOL);
        expect_idle(1'b0, "R7 idle after re-enumeration");

        // R12 fault during recovery ignored
        raise_fault(2'd1);
        @(negedge clk);
        fault_valid = 1'b1;
        fault_class = 2'd3;
        @(negedge clk);
        fault_valid = 1'b0;
        check(cur_level == 3'd2 && drain_req, "R12 fault ignored while busy", cur_level, 2);
        step(2, 1, 1'b1, "R12 original level kept", n, held, t1);

        // R9 storm by retry rate
        retry_rate = 8'd200;
        repeat (2) @(negedge clk);
        check(storm && freeze && !busy, "R9 storm freezes when idle", storm, 1);
        raise_fault(2'd0);
        step(2, 1, 1'b1, "R9 storm raises level", n, held, t1);
        expect_idle(1'b1, "R9 freeze kept in storm");
        retry_rate = 8'd199;
        repeat (2) @(negedge clk);
        check(!storm && !freeze, "R9 storm clears below limit", storm, 0);
        // R9 storm by latency
        lat_p95 = 8'd100;
        repeat (2) @(negedge clk);
        check(storm, "R9 latency storm", storm, 1);
        raise_fault(2'd2);
        step(4, 1, 1'b1, "R9 storm raises port to domain", n, held, t1);
        lat_p95 = 8'd0;
        repeat (2) @(negedge clk);
        check(!storm, "R9 latency storm clears", storm, 0);

        // R10 stale backlog windows
        for (int w = 0; w < 3; w++) tick(1'b0);
        @(negedge clk);
        check(!storm, "R10 three stale windows", storm, 0);
        tick(1'b0);
        @(negedge clk);
        check(storm && freeze, "R10 fourth stale window", storm, 1);
        tick(1'b1);
        @(negedge clk);
        check(!storm, "R10 falling backlog clears", storm, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule